// File: doc/BRIEF.md
# Dual Halfword Signed Multiply-Accumulate (64-bit)

This datapath unit takes two 32-bit operand words, each treated as a pair of signed 16-bit halfwords, plus a 64-bit accumulator presented as separate upper and lower 32-bit words. It multiplies the halfwords pairwise, sign-extends both products to 64 bits, adds them to the accumulator, and returns the 64-bit total split back into upper and lower words.

A crossing flag rotates the second operand by one halfword before multiplication. With the flag set, the low half of the first operand meets the high half of the second, and the high half of the first meets the low half of the second.

Operations enter through a valid/ready issue port and leave through a result port with valid/ready. There is one multiply stage and one accumulate stage. Results appear a fixed two cycles after acceptance, one operation can be accepted per cycle, and the whole pipeline holds when the result is not taken.

Top module: `dual_mac_long`

## Requirements
- R1: With `swap_i` low, the result equals {acc_hi_i,acc_lo_i} + A[15:0]*B[15:0] + A[31:16]*B[31:16]. All halfwords are two's-complement signed.
- R2: With `swap_i` high, B is rotated by 16 bits first, so the result equals acc + A[15:0]*B[31:16] + A[31:16]*B[15:0].
- R3: Each product is sign-extended to 64 bits before the addition, so a negative product borrows into the upper result word.
- R4: The 64-bit addition wraps modulo 2^64. No overflow indication exists on any port.
- R5: `res_hi_o` carries bits 63:32 of the sum and `res_lo_o` carries bits 31:0. The accumulator input takes `acc_hi_i` as bits 63:32 and `acc_lo_i` as bits 31:0.
- R6: When both products are (-32768)*(-32768), each equals 2^30 and their total 2^31 is added as a positive value, with no 32-bit truncation.
- R7: An operation accepted at clock edge k (`issue_valid_i` and `issue_ready_o` both high) raises `res_valid_o` right after edge k+1, whatever the operand values. `res_valid_o` is low between edges k and k+1 unless an earlier result is still held.
- R8: While `res_ready_i` is high, `issue_ready_o` stays high. One operation is accepted per cycle, and results leave in issue order.
- R9: While `res_valid_o` is high and `res_ready_i` is low, the result words stay stable. `issue_ready_o` goes low once both stages are occupied, and nothing is lost when the stall is released.
- R10: Asserting `rst_ni` low clears every valid flag: `res_valid_o` is 0 and `issue_ready_o` is 1 during reset and after it, including when an operation was in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Operation offered |
| issue_ready_o | output | 1 | Operation can be accepted |
| src_a_i | input | 32 | First operand, two signed halfwords |
| src_b_i | input | 32 | Second operand, two signed halfwords |
| swap_i | input | 1 | Cross the halfword pairing of the second operand |
| acc_hi_i | input | 32 | Accumulator bits 63:32 |
| acc_lo_i | input | 32 | Accumulator bits 31:0 |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Result taken by the consumer |
| res_hi_o | output | 32 | Result bits 63:32 |
| res_lo_o | output | 32 | Result bits 31:0 |

## Verification
The bench feeds both most-negative halfword pairs together. A design that sums the products in 32 bits would return a negative total there instead of +2^31. Negative products on a zero or all-ones accumulator show a missing sign extension as a wrong upper word, and an all-ones accumulator plus a positive product shows whether the sum wraps to zero. Crossed and straight pairings are applied to the same operands, which catches a reversed swap. Back-to-back issue and a held-off consumer catch a result that is lost, duplicated, reordered or changes while stalled, and catch latency that is off by a cycle.

// File: rtl/dmacl_pkg.sv
`timescale 1ns/1ps
package dmacl_pkg;
  parameter int DMACL_HALF_W = 16;

  typedef enum logic {
    PAIR_STRAIGHT = 1'b0,
    PAIR_CROSSED  = 1'b1
  } pair_e;
endpackage

// File: rtl/dmacl_pair_sel.sv
`timescale 1ns/1ps
module dmacl_pair_sel
  import dmacl_pkg::*;
#(
  parameter  int HALF_W = DMACL_HALF_W,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              swap_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] b_o
);
  pair_e mode;
  assign mode = pair_e'(swap_i);

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_comb begin
      if (mode == PAIR_CROSSED) b_o[h*HALF_W +: HALF_W] = b_i[(1-h)*HALF_W +: HALF_W];
      else                      b_o[h*HALF_W +: HALF_W] = b_i[h*HALF_W +: HALF_W];
    end
  end
endmodule

// File: rtl/dmacl_mul_stage.sv
`timescale 1ns/1ps
module dmacl_mul_stage
  import dmacl_pkg::*;
#(
  parameter  int HALF_W = DMACL_HALF_W,
  localparam int WORD_W = 2 * HALF_W,
  localparam int PROD_W = 2 * HALF_W,
  localparam int ACC_W  = 2 * WORD_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [WORD_W-1:0]      a_i,
  input  logic [WORD_W-1:0]      b_i,
  input  logic [ACC_W-1:0]       acc_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [1:0][PROD_W-1:0] prod_o,
  output logic [ACC_W-1:0]       acc_o
);
  localparam logic signed [PROD_W-1:0] PROD_MAX = $signed(PROD_W'(1) << (PROD_W - 2));
  localparam logic signed [PROD_W-1:0] PROD_MIN =
      -PROD_MAX + $signed(PROD_W'(1) << (HALF_W - 1));

  logic                   valid_q;
  logic                   load;
  logic [1:0][PROD_W-1:0] prod_d;
  logic [1:0][PROD_W-1:0] prod_q;
  logic [ACC_W-1:0]       acc_q;

  assign in_ready_o  = !valid_q || out_ready_i;
  assign load        = in_valid_i && in_ready_o;
  assign out_valid_o = valid_q;
  assign prod_o      = prod_q;
  assign acc_o       = acc_q;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [HALF_W-1:0] x, y;
    assign x = a_i[g*HALF_W +: HALF_W];
    assign y = b_i[g*HALF_W +: HALF_W];
    assign prod_d[g] = x * y;

    // full-width product range, (-2^15)^2 must survive as +2^30
    assert_prod_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |-> ($signed(prod_q[g]) <= PROD_MAX && $signed(prod_q[g]) >= PROD_MIN));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         valid_q <= 1'b0;
    else if (in_ready_o) valid_q <= in_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (load) begin
      prod_q <= prod_d;
      acc_q  <= acc_i;
    end
  end

  assert_issue_lands_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> out_valid_o);
endmodule

// File: rtl/dmacl_acc_stage.sv
`timescale 1ns/1ps
module dmacl_acc_stage
  import dmacl_pkg::*;
#(
  parameter  int HALF_W = DMACL_HALF_W,
  localparam int WORD_W = 2 * HALF_W,
  localparam int PROD_W = 2 * HALF_W,
  localparam int ACC_W  = 2 * WORD_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [1:0][PROD_W-1:0] prod_i,
  input  logic [ACC_W-1:0]       acc_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [ACC_W-1:0]       sum_o
);
  logic             valid_q;
  logic [ACC_W-1:0] sum_d;
  logic [ACC_W-1:0] sum_q;
  logic [1:0][ACC_W-1:0] prod_ext;

  assign in_ready_o  = !valid_q || out_ready_i;
  assign out_valid_o = valid_q;
  assign sum_o       = sum_q;

  for (genvar g = 0; g < 2; g++) begin : g_ext
    assign prod_ext[g] = ACC_W'($signed(prod_i[g]));
  end

  // three-way add, carries beyond ACC_W dropped: wraps mod 2^ACC_W
  assign sum_d = acc_i + prod_ext[0] + prod_ext[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         valid_q <= 1'b0;
    else if (in_ready_o) valid_q <= in_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (in_valid_i && in_ready_o) sum_q <= sum_d;
  end

  assert_hold_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(sum_o)));

  assert_result_sourced_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_valid_o && in_valid_i) |=> out_valid_o);
endmodule

// File: rtl/dual_mac_long.sv
`timescale 1ns/1ps
module dual_mac_long
  import dmacl_pkg::*;
#(
  parameter  int HALF_W = DMACL_HALF_W,
  localparam int WORD_W = 2 * HALF_W,
  localparam int PROD_W = 2 * HALF_W,
  localparam int ACC_W  = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  output logic              issue_ready_o,
  input  logic [WORD_W-1:0] src_a_i,
  input  logic [WORD_W-1:0] src_b_i,
  input  logic              swap_i,
  input  logic [WORD_W-1:0] acc_hi_i,
  input  logic [WORD_W-1:0] acc_lo_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [WORD_W-1:0] res_hi_o,
  output logic [WORD_W-1:0] res_lo_o
);
  logic [WORD_W-1:0]      b_paired;
  logic                   s1_valid, s2_ready;
  logic [1:0][PROD_W-1:0] s1_prod;
  logic [ACC_W-1:0]       s1_acc;
  logic [ACC_W-1:0]       sum;

  dmacl_pair_sel #(.HALF_W(HALF_W)) u_pair (
    .swap_i (swap_i),
    .b_i    (src_b_i),
    .b_o    (b_paired)
  );

  dmacl_mul_stage #(.HALF_W(HALF_W)) u_mul (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (issue_valid_i),
    .in_ready_o  (issue_ready_o),
    .a_i         (src_a_i),
    .b_i         (b_paired),
    .acc_i       ({acc_hi_i, acc_lo_i}),
    .out_valid_o (s1_valid),
    .out_ready_i (s2_ready),
    .prod_o      (s1_prod),
    .acc_o       (s1_acc)
  );

  dmacl_acc_stage #(.HALF_W(HALF_W)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (s1_valid),
    .in_ready_o  (s2_ready),
    .prod_i      (s1_prod),
    .acc_i       (s1_acc),
    .out_valid_o (res_valid_o),
    .out_ready_i (res_ready_i),
    .sum_o       (sum)
  );

  assign res_hi_o = sum[ACC_W-1:WORD_W];
  assign res_lo_o = sum[WORD_W-1:0];

  assert_backpressure_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_ready_o |-> (res_valid_o && !res_ready_i));

  assert_flow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_ready_i |-> issue_ready_o);
endmodule

// File: tb/dual_mac_long_tb.sv
`timescale 1ns/1ps
module dual_mac_long_tb;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iv = 1'b0, sw = 1'b0, rr = 1'b1;
  logic [31:0] a = '0, b = '0, ahi = '0, alo = '0;
  logic        ir, rv;
  logic [31:0] rhi, rlo;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dual_mac_long u_dut (
    .clk_i(clk), .rst_ni(rst_n), .issue_valid_i(iv), .issue_ready_o(ir),
    .src_a_i(a), .src_b_i(b), .swap_i(sw), .acc_hi_i(ahi), .acc_lo_i(alo),
    .res_valid_o(rv), .res_ready_i(rr), .res_hi_o(rhi), .res_lo_o(rlo)
  );

  // {a, b, swap, acc_hi, acc_lo}
  localparam logic [128:0] VEC [NV] = '{
    {32'h0003_0002, 32'h0005_0004, 1'b0, 32'h0000_0000, 32'h0000_0000},
    {32'h0003_0002, 32'h0005_0004, 1'b1, 32'h0000_0000, 32'h0000_0000},
    {32'hFFFF_0001, 32'h0002_0003, 1'b0, 32'h0000_0000, 32'h0000_0010},
    {32'h0000_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0001, 32'h0000_0000},
    {32'h8000_8000, 32'h8000_8000, 1'b0, 32'h0000_0000, 32'h0000_0000},
    {32'h8000_8000, 32'h8000_8000, 1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF},
    {32'h7FFF_7FFF, 32'h8000_8000, 1'b0, 32'h0000_0000, 32'h0000_0000},
    {32'h0000_0001, 32'h0000_0001, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h8000_7FFF, 32'h7FFF_8000, 1'b1, 32'h0123_4567, 32'h89AB_CDEF}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2: return "R1";
      3: return "R3";
      4: return "R6";
      5: return "R4";
      6: return "R3";
      7: return "R4";
      8: return "R2";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [63:0] model(logic [31:0] x, logic [31:0] y, logic s,
                                        logic [63:0] acc);
    logic [31:0] yy;
    logic signed [15:0] x0, x1, y0, y1;
    logic signed [63:0] p0, p1;
    yy = s ? {y[15:0], y[31:16]} : y;
    x0 = x[15:0]; x1 = x[31:16];
    y0 = yy[15:0]; y1 = yy[31:16];
    p0 = x0 * y0;
    p1 = x1 * y1;
    return acc + p0 + p1;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(int i);
    {a, b, sw, ahi, alo} = VEC[i];
    iv = 1'b1;
  endtask

  task automatic chk_res(string tag, logic [63:0] exp);
    chk({tag, " valid"}, 64'(rv), 64'd1);
    chk({tag, "/R5 hi"}, 64'(rhi), 64'(exp[63:32]));
    chk({tag, "/R5 lo"}, 64'(rlo), 64'(exp[31:0]));
  endtask

  function automatic logic [63:0] vexp(int i);
    logic [31:0] x, y, h, l;
    logic s;
    {x, y, s, h, l} = VEC[i];
    return model(x, y, s, {h, l});
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", 64'(rv), 64'd0);
    chk("R10 ready in reset", 64'(ir), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 valid after reset", 64'(rv), 64'd0);

    // table walk: one op at a time, fixed latency for every operand set
    for (int i = 0; i < NV; i++) begin
      drive(i);
      @(negedge clk);
      iv = 1'b0;
      chk({vtag(i), "/R7 not early"}, 64'(rv), 64'd0);
      @(negedge clk);
      chk_res({vtag(i), "/R7"}, vexp(i));
    end
    @(negedge clk);
    chk("R7 drained", 64'(rv), 64'd0);

    // R8 back-to-back stream
    for (int k = 0; k < 6; k++) begin
      if (k >= 2) chk_res("R8 stream", vexp(k + 1));
      if (k < 4) begin
        chk("R8 ready", 64'(ir), 64'd1);
        drive(k + 3);
      end else iv = 1'b0;
      @(negedge clk);
    end
    chk("R8 stream end", 64'(rv), 64'd0);

    // R9 stall with full pipe
    rr = 1'b0;
    drive(4);
    @(negedge clk);
    chk("R9 ready one busy", 64'(ir), 64'd1);
    drive(5);
    @(negedge clk);
    drive(6);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 ready low", 64'(ir), 64'd0);
      chk_res("R9 held", vexp(4));
    end
    rr = 1'b1;
    @(negedge clk);
    iv = 1'b0;
    chk_res("R9 second", vexp(5));
    @(negedge clk);
    chk_res("R9 third", vexp(6));
    @(negedge clk);
    chk("R9 empty", 64'(rv), 64'd0);

    // R10 reset with op in flight
    drive(0);
    @(negedge clk);
    iv = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 flushed valid", 64'(rv), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 no ghost", 64'(rv), 64'd0);
    chk("R10 ready", 64'(ir), 64'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule